// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Amount Shifts

This block runs integer instructions against a private file of sixteen 64-bit registers. It handles add, subtract, negate, absolute value, multiply, multiply-accumulate and multiply-subtract, each in a 32-bit form that works on the low half of a register and a 64-bit form that works on the whole register. It also shifts registers by a signed amount. The amount comes either from a 7-bit immediate that is split across two fields of the instruction word or from a 32-bit signed count that the host supplies next to the instruction. A negative amount is an arithmetic right shift and a non-negative amount is a left shift.

Instructions arrive on a valid/ready stream. The unit accepts a word on a clock edge where `op_valid` and `op_ready` are both high. It then drops `op_ready` for one cycle while it computes. At the next edge it writes the destination register and pulses `wb_done`. The producer must hold `op_word` and `host_shamt` stable while `op_valid` is high and `op_ready` is low, and nothing is taken on those cycles. The host fills registers through a plain load port and reads any register back through a combinational peek port.

Top module: `int_exec_unit`

## Requirements
- R1: After reset every register reads zero, `op_ready` is high and `wb_done` and `wb_illegal` are low.
- R2: A word is accepted on an edge with `op_valid` and `op_ready` both high. `op_ready` is low for exactly the following cycle. The register write and a one-cycle `wb_done` pulse occur at the second edge after acceptance. A word presented while `op_ready` is low is not accepted.
- R3: Field layout: group select in bits 21:20, sub-operation in bits 7:5, destination index in bits 15:12, source A in bits 19:16, source B in bits 3:0. Group 3 decodes sub 0 abs32, 1 abs64, 2 neg32, 3 neg64, 4 add32, 5 add64, 6 sub32, 7 sub64. A 32-bit operation writes a modulo-2^32 result into the low half of the destination and leaves its upper half unchanged.
- R4: The 64-bit forms read and write whole registers, with results taken modulo 2^64.
- R5: Absolute value returns the two's-complement negation of a negative operand and the operand itself otherwise, in both widths.
- R6: Group 1 decodes sub 0 mul32 (low 32 bits of the product of the low halves), sub 1 mul64 (low 64 bits of the full product), sub 2 multiply-accumulate (destination low half plus the 32-bit product of the source low halves) and sub 3 multiply-subtract (destination low half minus that product).
- R7: Group 0 shifts the low half and group 2 shifts the whole register of source A into the destination. The amount is the 7-bit two's-complement value with bits 7:5 of the word as its top three bits and bits 3:0 as its low four. A non-negative amount shifts left.
- R8: A negative amount shifts arithmetically right by its magnitude. A magnitude of at least the operand width gives all copies of the sign bit when shifting right and zero when shifting left.
- R9: With bit 24 set, the word is a register shift. Bit 20 selects the width (0: 32-bit, 1: 64-bit), the source is indexed by bits 19:16 and the destination by bits 3:0. The amount is `host_shamt` read as a 32-bit signed value, under the rules of R7 and R8.
- R10: A word is illegal when any reserved bit (31:25, 23:22, 11:8 or 4) is set, when group 1 has sub 4 to 7, or when a register shift has bit 21 set. An illegal word pulses `wb_illegal` together with `wb_done` and changes no register.
- R11: When `ld_en` is high, `ld_data` is written into register `ld_idx` at the clock edge. If an execute write-back hits the same register at the same edge, the write-back value is kept.
- R12: `peek_data` shows register `peek_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Instruction word is presented |
| op_ready | output | 1 | Unit can accept an instruction this cycle |
| op_word | input | 32 | Instruction word |
| host_shamt | input | 32 | Signed shift count for register-shift words |
| ld_en | input | 1 | Host register load enable |
| ld_idx | input | 4 | Host load register index |
| ld_data | input | 64 | Host load value |
| peek_idx | input | 4 | Readback register index |
| peek_data | output | 64 | Readback register value |
| wb_done | output | 1 | One-cycle pulse after an instruction retires |
| wb_illegal | output | 1 | With `wb_done`: the retired word was illegal |

## Verification
A fault in the decode or the operand stage can only show in the register that the retiring instruction writes. The peek port exposes that register one cycle after acceptance, so every stimulus reloads all registers to known values, runs one word and reads back its destination, or for illegal words the register that would have been hit. A stuck or mistimed stage register shows at the handshake pins at once: `op_ready` does not drop for the single busy cycle, or `wb_done` does not pulse two edges after acceptance. A priority error between the load port and write-back shows in the one register that both target at the same edge.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int REG_CNT = 16;
  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int WORD_W  = 64;
  localparam int HALF_W  = WORD_W / 2;
  localparam int AMT_W   = 32;
  localparam int INS_W   = 32;

  typedef enum logic [4:0] {
    OP_ILL,
    OP_ABS32, OP_ABS64, OP_NEG32, OP_NEG64,
    OP_ADD32, OP_ADD64, OP_SUB32, OP_SUB64,
    OP_MUL32, OP_MUL64, OP_MAC32, OP_MSC32,
    OP_SH32,  OP_SH64
  } op_e;

  typedef struct packed {
    op_e                     op;
    logic [IDX_W-1:0]        dst;
    logic [IDX_W-1:0]        sa;
    logic [IDX_W-1:0]        sb;
    logic signed [AMT_W-1:0] amt;
  } dec_t;
endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [INS_W-1:0] word,
  input  logic [AMT_W-1:0] host_amt,
  output dec_t             dec
);
  logic rsv;
  logic [AMT_W-1:0] imm_amt;

  assign rsv     = |{word[31:25], word[23:22], word[11:8], word[4]};
  assign imm_amt = {{(AMT_W-7){word[7]}}, word[7:5], word[3:0]};

  always_comb begin
    dec.op  = OP_ILL;
    dec.dst = word[15:12];
    dec.sa  = word[19:16];
    dec.sb  = word[3:0];
    dec.amt = imm_amt;
    if (!rsv) begin
      if (word[24]) begin
        dec.dst = word[3:0];
        dec.amt = host_amt;
        if (!word[21]) dec.op = word[20] ? OP_SH64 : OP_SH32;
      end else begin
        unique case (word[21:20])
          2'd0: dec.op = OP_SH32;
          2'd2: dec.op = OP_SH64;
          2'd1: begin
            unique case (word[7:5])
              3'd0:    dec.op = OP_MUL32;
              3'd1:    dec.op = OP_MUL64;
              3'd2:    dec.op = OP_MAC32;
              3'd3:    dec.op = OP_MSC32;
              default: dec.op = OP_ILL;
            endcase
          end
          default: begin
            unique case (word[7:5])
              3'd0: dec.op = OP_ABS32;
              3'd1: dec.op = OP_ABS64;
              3'd2: dec.op = OP_NEG32;
              3'd3: dec.op = OP_NEG64;
              3'd4: dec.op = OP_ADD32;
              3'd5: dec.op = OP_ADD64;
              3'd6: dec.op = OP_SUB32;
              default: dec.op = OP_SUB64;
            endcase
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/iexu_regfile.sv
module iexu_regfile #(
  parameter int NREG = 16,
  parameter int W    = 64,
  parameter int NRD  = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_x,
  input  logic [IW-1:0]         wa_x,
  input  logic [W-1:0]          wd_x,
  input  logic                  we_h,
  input  logic [IW-1:0]         wa_h,
  input  logic [W-1:0]          wd_h,
  input  logic [NRD-1:0][IW-1:0] ra,
  output logic [NRD-1:0][W-1:0]  rd
);
  logic [W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q[i] <= '0;
      else if (we_x && wa_x == IW'(i))     q[i] <= wd_x;
      else if (we_h && wa_h == IW'(i))     q[i] <= wd_h;
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd[k] = q[ra[k]];
  end
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift #(
  parameter int W  = 32,
  parameter int AW = 32,
  localparam int SB = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  y
);
  logic [AW-1:0] mag;
  logic          neg;

  assign neg = amt[AW-1];
  assign mag = neg ? (~amt + AW'(1)) : amt;

  always_comb begin
    if (neg) begin
      if (mag >= AW'(W)) y = {W{a[W-1]}};
      else               y = W'($signed(a) >>> mag[SB-1:0]);
    end else begin
      if (mag >= AW'(W)) y = '0;
      else               y = a << mag[SB-1:0];
    end
  end
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
(
  input  op_e                 op,
  input  logic [WORD_W-1:0]   a,
  input  logic [WORD_W-1:0]   b,
  input  logic [WORD_W-1:0]   c,
  input  logic [AMT_W-1:0]    amt,
  output logic [WORD_W-1:0]   y
);
  logic [HALF_W-1:0] al, bl, cl, prod32, sh32, r32;
  logic [WORD_W-1:0] sh64;

  assign al     = a[HALF_W-1:0];
  assign bl     = b[HALF_W-1:0];
  assign cl     = c[HALF_W-1:0];
  assign prod32 = al * bl;

  iexu_shift #(.W(HALF_W), .AW(AMT_W)) u_sh_lo (.a(al), .amt(amt), .y(sh32));
  iexu_shift #(.W(WORD_W), .AW(AMT_W)) u_sh_wd (.a(a),  .amt(amt), .y(sh64));

  always_comb begin
    unique case (op)
      OP_ABS32: r32 = al[HALF_W-1] ? -al : al;
      OP_NEG32: r32 = -al;
      OP_ADD32: r32 = al + bl;
      OP_SUB32: r32 = al - bl;
      OP_MUL32: r32 = prod32;
      OP_MAC32: r32 = cl + prod32;
      OP_MSC32: r32 = cl - prod32;
      OP_SH32:  r32 = sh32;
      default:  r32 = cl;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_ABS64: y = a[WORD_W-1] ? -a : a;
      OP_NEG64: y = -a;
      OP_ADD64: y = a + b;
      OP_SUB64: y = a - b;
      OP_MUL64: y = a * b;
      OP_SH64:  y = sh64;
      OP_ILL:   y = c;
      default:  y = {c[WORD_W-1:HALF_W], r32};
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic [INS_W-1:0]    op_word,
  input  logic [AMT_W-1:0]    host_shamt,
  input  logic                ld_en,
  input  logic [IDX_W-1:0]    ld_idx,
  input  logic [WORD_W-1:0]   ld_data,
  input  logic [IDX_W-1:0]    peek_idx,
  output logic [WORD_W-1:0]   peek_data,
  output logic                wb_done,
  output logic                wb_illegal
);
  localparam int NRD = 4;

  dec_t dec;
  logic accept;
  logic [NRD-1:0][IDX_W-1:0]  ra;
  logic [NRD-1:0][WORD_W-1:0] rdat;

  logic               s_vld;
  op_e                s_op;
  logic [IDX_W-1:0]   s_dst;
  logic [WORD_W-1:0]  s_a, s_b, s_c;
  logic [AMT_W-1:0]   s_amt;
  logic [WORD_W-1:0]  res;

  iexu_decode u_dec (.word(op_word), .host_amt(host_shamt), .dec(dec));

  assign ra = {peek_idx, dec.dst, dec.sb, dec.sa};

  iexu_regfile #(.NREG(REG_CNT), .W(WORD_W), .NRD(NRD)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we_x (s_vld && s_op != OP_ILL),
    .wa_x (s_dst),
    .wd_x (res),
    .we_h (ld_en),
    .wa_h (ld_idx),
    .wd_h (ld_data),
    .ra   (ra),
    .rd   (rdat)
  );

  assign peek_data = rdat[3];
  assign op_ready  = !s_vld;
  assign accept    = op_valid && op_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld      <= 1'b0;
      s_op       <= OP_ILL;
      s_dst      <= '0;
      s_a        <= '0;
      s_b        <= '0;
      s_c        <= '0;
      s_amt      <= '0;
      wb_done    <= 1'b0;
      wb_illegal <= 1'b0;
    end else begin
      wb_done    <= s_vld;
      wb_illegal <= s_vld && (s_op == OP_ILL);
      s_vld      <= accept;
      if (accept) begin
        s_op  <= dec.op;
        s_dst <= dec.dst;
        s_a   <= rdat[0];
        s_b   <= rdat[1];
        s_c   <= rdat[2];
        s_amt <= dec.amt;
      end
    end
  end

  iexu_alu u_alu (.op(s_op), .a(s_a), .b(s_b), .c(s_c), .amt(s_amt), .y(res));
endmodule

// File: rtl/iexu_chk.sv
module iexu_chk #(
  parameter int IW = 4,
  parameter int W  = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic          ld_en,
  input logic [IW-1:0] ld_idx,
  input logic [W-1:0]  ld_data,
  input logic [IW-1:0] peek_idx,
  input logic [W-1:0]  peek_data,
  input logic          wb_done,
  input logic          wb_illegal
);
  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);

  // R2
  busy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |=> op_ready);

  // R2
  done_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> ##1 wb_done);

  // R2
  done_only_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |-> $past(!op_ready));

  // R10
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_illegal |-> wb_done);

  // R11
  host_load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && op_ready && peek_idx == ld_idx) |=>
      (!$stable(peek_idx) || peek_data == $past(ld_data)));
endmodule

bind int_exec_unit iexu_chk #(.IW(iexu_pkg::IDX_W), .W(iexu_pkg::WORD_W)) u_iexu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_ready  (op_ready),
  .ld_en     (ld_en),
  .ld_idx    (ld_idx),
  .ld_data   (ld_data),
  .peek_idx  (peek_idx),
  .peek_data (peek_data),
  .wb_done   (wb_done),
  .wb_illegal(wb_illegal)
);

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;
  localparam int CLK_NS = 10;
  localparam int NV     = 27;

  typedef struct packed {
    logic [31:0] word;
    logic [31:0] shamt;
    logic [3:0]  idx;
    logic [63:0] exp;
    logic        ill;
  } vec_t;

  function automatic logic [31:0] mk(input int g, input int s, input int d, input int a, input int b);
    return 32'((g << 20) | (s << 5) | (d << 12) | (a << 16) | b);
  endfunction

  function automatic logic [31:0] shi(input int g, input int d, input int a, input int amt7);
    return mk(g, (amt7 >> 4) & 7, d, a, amt7 & 15);
  endfunction

  function automatic logic [31:0] rsh(input int w, input int a, input int d);
    return 32'((1 << 24) | (w << 20) | (a << 16) | d);
  endfunction

  function automatic logic [63:0] base(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'hAAAA_AAAA_0000_0007;
      2: return 64'h5555_5555_FFFF_FFFD;
      3: return 64'h0000_0000_8000_0000;
      4: return 64'hFFFF_FFFF_FFFF_FFF0;
      5: return 64'h0000_0001_0000_0000;
      6: return 64'h1234_5678_0000_0064;
      default: return {32'hC0DE_0000, 28'h0, 4'(i)};
    endcase
  endfunction

  localparam vec_t VEC [NV] = '{
    '{mk(3,4,8,1,2),  32'd0, 4'd8,  64'hC0DE_0000_0000_0004, 1'b0},
    '{mk(3,6,8,1,2),  32'd0, 4'd8,  64'hC0DE_0000_0000_000A, 1'b0},
    '{mk(3,2,8,3,0),  32'd0, 4'd8,  64'hC0DE_0000_8000_0000, 1'b0},
    '{mk(3,0,8,2,0),  32'd0, 4'd8,  64'hC0DE_0000_0000_0003, 1'b0},
    '{mk(3,1,8,4,0),  32'd0, 4'd8,  64'h0000_0000_0000_0010, 1'b0},
    '{mk(3,3,8,5,0),  32'd0, 4'd8,  64'hFFFF_FFFF_0000_0000, 1'b0},
    '{mk(3,5,8,4,5),  32'd0, 4'd8,  64'h0000_0000_FFFF_FFF0, 1'b0},
    '{mk(3,7,8,5,4),  32'd0, 4'd8,  64'h0000_0001_0000_0010, 1'b0},
    '{mk(1,0,8,1,2),  32'd0, 4'd8,  64'hC0DE_0000_FFFF_FFEB, 1'b0},
    '{mk(1,1,8,4,5),  32'd0, 4'd8,  64'hFFFF_FFF0_0000_0000, 1'b0},
    '{mk(1,2,8,1,6),  32'd0, 4'd8,  64'hC0DE_0000_0000_02C4, 1'b0},
    '{mk(1,3,8,1,2),  32'd0, 4'd8,  64'hC0DE_0000_0000_001D, 1'b0},
    '{shi(0,8,1,4),   32'd0, 4'd8,  64'hC0DE_0000_0000_0070, 1'b0},
    '{shi(0,8,2,127), 32'd0, 4'd8,  64'hC0DE_0000_FFFF_FFFE, 1'b0},
    '{shi(0,8,3,88),  32'd0, 4'd8,  64'hC0DE_0000_FFFF_FFFF, 1'b0},
    '{shi(0,8,1,63),  32'd0, 4'd8,  64'hC0DE_0000_0000_0000, 1'b0},
    '{shi(2,8,6,8),   32'd0, 4'd8,  64'h3456_7800_0000_6400, 1'b0},
    '{shi(2,8,4,124), 32'd0, 4'd8,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    '{shi(2,8,4,64),  32'd0, 4'd8,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    '{shi(2,8,2,96),  32'd0, 4'd8,  64'h0000_0000_5555_5555, 1'b0},
    '{rsh(0,1,9),     -32'sd2,    4'd9,  64'hC0DE_0000_0000_0001, 1'b0},
    '{rsh(1,6,10),    32'd4,      4'd10, 64'h2345_6780_0000_0640, 1'b0},
    '{rsh(0,1,9),     32'd100,    4'd9,  64'hC0DE_0000_0000_0000, 1'b0},
    '{rsh(1,4,10),    -32'sd1000, 4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    '{mk(1,4,8,1,2),  32'd0, 4'd8,  64'hC0DE_0000_0000_0008, 1'b1},
    '{rsh(3,1,9),     32'd1, 4'd9,  64'hC0DE_0000_0000_0009, 1'b1},
    '{mk(3,4,8,1,2) | 32'h10, 32'd0, 4'd8, 64'hC0DE_0000_0000_0008, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [31:0] op_word = '0;
  logic [31:0] host_shamt = '0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [63:0] ld_data = '0;
  logic [3:0]  peek_idx = '0;
  logic [63:0] peek_data;
  logic        wb_done, wb_illegal;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_word(op_word), .host_shamt(host_shamt), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .peek_idx(peek_idx), .peek_data(peek_data),
    .wb_done(wb_done), .wb_illegal(wb_illegal)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [31:0] w);
    if (w[24])                       return "R9";
    if (w[21:20] == 2'd1)            return "R6";
    if (w[21:20] == 2'd0 || w[21:20] == 2'd2) return w[7] ? "R8" : "R7";
    if (w[7:5] <= 3'd1)              return "R5";
    return w[5] ? "R4" : "R3";
  endfunction

  task automatic load_all();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 4'(i); ld_data = base(i);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input int i, output logic [63:0] v);
    peek_idx = 4'(i);
    #1;
    v = peek_data;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] sh);
    op_valid = 1'b1; op_word = w; host_shamt = sh;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(op_ready), 64'd1);
    chk("R1 done", 64'({wb_done, wb_illegal}), 64'd0);
    peek(6, v); chk("R1 reg6", v, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    peek(1, v); chk("R1 reg1", v, 64'h0);

    // R11 and R12: host load then peek
    load_all();
    peek(6, v); chk("R11 load", v, base(6));
    peek(2, v); chk("R12 peek", v, base(2));

    for (int k = 0; k < NV; k++) begin
      load_all();
      issue(VEC[k].word, VEC[k].shamt);
      chk("R2 busy", 64'(op_ready), 64'd0);
      @(negedge clk);
      chk("R2 done", 64'(wb_done), 64'd1);
      chk("R10 flag", 64'(wb_illegal), 64'(VEC[k].ill));
      peek(VEC[k].idx, v);
      chk(VEC[k].ill ? "R10 nowrite" : tag_of(VEC[k].word), v, VEC[k].exp);
    end

    // R2: word held through the busy cycle is accepted once (mac would double)
    load_all();
    op_valid = 1'b1; op_word = mk(1,2,8,1,6); host_shamt = '0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R2 held", 64'(wb_done), 64'd1);
    @(negedge clk);
    peek(8, v); chk("R2 single accept", v, 64'hC0DE_0000_0000_02C4);
    chk("R2 no second done", 64'(wb_done), 64'd0);

    // R11: write-back beats host load on the same register
    load_all();
    op_valid = 1'b1; op_word = mk(3,4,8,1,2);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    ld_en = 1'b1; ld_idx = 4'd8; ld_data = 64'h1111_2222_3333_4444;
    @(negedge clk);
    ld_en = 1'b0;
    peek(8, v); chk("R11 priority", v, 64'hC0DE_0000_0000_0004);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule